// File: doc/BRIEF.md
# Sensor Soft-Reset and Standby Sequencer

This block sits beside the frame timing logic of an image sensor's digital core and owns two duties. The first is a small reset control register reached through a plain register write/read port. Writing it emits single-cycle reset pulses, either to the whole digital core or only to the automatic gain and exposure unit. The core reset also abandons the frame being produced. The register bits clear themselves and always read as zero. Its own register port is not affected by the core reset it issues, so configuration held on that port survives.

The second duty is power sequencing. An asynchronous standby request is brought in through a two-flop synchronizer. When it is seen, the block lets the frame in flight run to its end-of-frame strobe. Only then does it drop the clock-gate enable, logic enable and analog power enable. If no frame is open, it shuts down at once. A soft reset issued while the block waits cancels the wait. Dropping the request brings all three enables back.

Top module: `snsr_pwr_ctrl`

## Requirements
- R1: A write to address 0x0C with data bit 0 set drives `core_soft_rst` high for exactly one cycle, in the cycle after the write.
- R2: A write to address 0x0C with data bit 1 set drives `gain_exp_rst` high for exactly one cycle, in the cycle after the write. Bit 0 alone does not drive it, and bit 1 alone does not drive `core_soft_rst`.
- R3: Writes to any address other than 0x0C produce no reset pulse.
- R4: `reg_rdata` is registered, valid the cycle after `reg_rd_en`, and reads as zero for address 0x0C, including while a reset pulse is active.
- R5: A soft reset closes the open frame, so a later standby request shuts down without waiting for an end-of-frame strobe.
- R6: With no frame open, raising `standby_req` drops all three enables in the third cycle after the change, with two synchronizer stages and one state register.
- R7: With a frame open (opened by `sof`), a standby request holds the enables high until `eof` is sampled; they drop in the following cycle.
- R8: Lowering `standby_req` raises all three enables in the third cycle after the change.
- R9: A soft reset while waiting for end of frame drops the enables in the cycle after the reset pulse.
- R10: Withdrawing standby while waiting for end of frame keeps the enables high, including after the later `eof`.
- R11: After `rst_n` the enables are high, both pulses are low and `reg_rdata` is zero.
- R12: `sof` and `eof` in the same cycle end one frame and open the next, so a following standby request still waits for an `eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| sof | input | 1 | Start-of-frame strobe |
| eof | input | 1 | End-of-frame strobe |
| standby_req | input | 1 | Asynchronous standby request, active high |
| core_soft_rst | output | 1 | One-cycle digital core reset, which also restarts framing |
| gain_exp_rst | output | 1 | One-cycle gain/exposure unit reset |
| clk_gate_en | output | 1 | Internal clock gate enable |
| logic_en | output | 1 | Digital logic enable |
| analog_pwr_en | output | 1 | Analog power enable |

## Verification
The register port is driven with each reset bit alone, with both bits together, and with writes to a neighbouring address. These cases separate a bit-decoding error from an address-decoding error. Standby requests are given with no frame open, during an open frame, with a soft reset during the wait, with the request withdrawn during the wait, and after a coincident start and end strobe. Each case tells apart whether the shutdown is immediate, waits for a frame, or is cancelled. A behavioural model in the bench tracks every output cycle by cycle across all of these cases. Edge-exact checks measure the three-cycle synchronizer latency in both directions.

// File: rtl/snsr_ctl_pkg.sv
package snsr_ctl_pkg;

    typedef enum logic [1:0] {
        PW_RUN   = 2'd0,
        PW_DRAIN = 2'd1,
        PW_SLEEP = 2'd2
    } pw_state_e;

endpackage

// File: rtl/snsr_sync.sv
module snsr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/snsr_rst_regs.sv
module snsr_rst_regs #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 16,
    parameter logic [7:0]  RST_ADDR = 8'h0C,
    parameter int          CORE_BIT = 0,
    parameter int          GEXP_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              core_rst,
    output logic              gexp_rst
);

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(RST_ADDR);
    localparam logic [DATA_W-1:0] SELF_CLR = (DATA_W'(1) << CORE_BIT) | (DATA_W'(1) << GEXP_BIT);

    typedef struct packed {
        logic              core;
        logic              gexp;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit;
    logic [DATA_W-1:0] image;

    always_comb begin
        hit   = (addr == HIT_ADDR);
        image = '0;
        image[CORE_BIT] = r_q.core;
        image[GEXP_BIT] = r_q.gexp;

        r_d       = r_q;
        r_d.core  = wr_en && hit && wdata[CORE_BIT];
        r_d.gexp  = wr_en && hit && wdata[GEXP_BIT];
        r_d.rdata = '0;
        if (rd_en && hit) begin
            r_d.rdata = image & ~SELF_CLR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign core_rst = r_q.core;
    assign gexp_rst = r_q.gexp;
    assign rdata    = r_q.rdata;

endmodule

// File: rtl/snsr_stby_fsm.sv
module snsr_stby_fsm
    import snsr_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stby_s,
    input  logic      sof,
    input  logic      eof,
    input  logic      soft_rst,
    output pw_state_e state,
    output logic      frame_open,
    output logic      clk_en,
    output logic      logic_en,
    output logic      ana_en
);

    typedef struct packed {
        pw_state_e st;
        logic      open;
        logic      clk_en;
        logic      logic_en;
        logic      ana_en;
    } fsm_t;

    fsm_t f_d, f_q;
    logic busy;
    logic awake;

    always_comb begin
        f_d  = f_q;
        busy = !soft_rst && ((f_q.open && !eof) || sof);

        case (f_q.st)
            PW_RUN: begin
                if (stby_s) begin
                    f_d.st = busy ? PW_DRAIN : PW_SLEEP;
                end
            end
            PW_DRAIN: begin
                if (soft_rst) begin
                    f_d.st = PW_SLEEP;
                end else if (!stby_s) begin
                    f_d.st = PW_RUN;
                end else if (eof) begin
                    f_d.st = PW_SLEEP;
                end
            end
            PW_SLEEP: begin
                if (!stby_s) begin
                    f_d.st = PW_RUN;
                end
            end
            default: f_d.st = PW_RUN;
        endcase

        if (soft_rst || f_d.st == PW_SLEEP) begin
            f_d.open = 1'b0;
        end else if (sof) begin
            f_d.open = 1'b1;
        end else if (eof) begin
            f_d.open = 1'b0;
        end

        awake        = (f_d.st != PW_SLEEP);
        f_d.clk_en   = awake;
        f_d.logic_en = awake;
        f_d.ana_en   = awake;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st       <= PW_RUN;
            f_q.open     <= 1'b0;
            f_q.clk_en   <= 1'b1;
            f_q.logic_en <= 1'b1;
            f_q.ana_en   <= 1'b1;
        end else begin
            f_q <= f_d;
        end
    end

    assign state      = f_q.st;
    assign frame_open = f_q.open;
    assign clk_en     = f_q.clk_en;
    assign logic_en   = f_q.logic_en;
    assign ana_en     = f_q.ana_en;

endmodule

// File: rtl/snsr_pwr_ctrl.sv
module snsr_pwr_ctrl
    import snsr_ctl_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 16,
    parameter logic [7:0] RST_ADDR    = 8'h0C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sof,
    input  logic              eof,
    input  logic              standby_req,
    output logic              core_soft_rst,
    output logic              gain_exp_rst,
    output logic              clk_gate_en,
    output logic              logic_en,
    output logic              analog_pwr_en
);

    logic      stby_sync;
    pw_state_e pw_state;
    logic      frame_open;

    snsr_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (standby_req),
        .sync_out (stby_sync)
    );

    snsr_rst_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RST_ADDR (RST_ADDR),
        .CORE_BIT (0),
        .GEXP_BIT (1)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .rd_en    (reg_rd_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .core_rst (core_soft_rst),
        .gexp_rst (gain_exp_rst)
    );

    snsr_stby_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stby_s     (stby_sync),
        .sof        (sof),
        .eof        (eof),
        .soft_rst   (core_soft_rst),
        .state      (pw_state),
        .frame_open (frame_open),
        .clk_en     (clk_gate_en),
        .logic_en   (logic_en),
        .ana_en     (analog_pwr_en)
    );

endmodule

// File: rtl/snsr_pwr_chk.sv
module snsr_pwr_chk
    import snsr_ctl_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 16,
    parameter logic [7:0] RST_ADDR = 8'h0C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              core_rst,
    input logic              gexp_rst,
    input logic              stby_s,
    input logic              sof,
    input logic              eof,
    input pw_state_e         state,
    input logic              frame_open,
    input logic              logic_en
);

    localparam logic [ADDR_W-1:0] HIT = ADDR_W'(RST_ADDR);

    p_core_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == HIT && wdata[0]) |=> core_rst);

    p_core_only_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == HIT && wdata[0])) |=> !core_rst);

    p_gexp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == HIT && wdata[1]) |=> gexp_rst);

    p_gexp_only_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == HIT && wdata[1])) |=> !gexp_rst);

    p_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rdata == '0));

    p_idle_shutdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PW_RUN && stby_s && !frame_open && !sof) |=> !logic_en);

    p_drain_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PW_DRAIN && stby_s && !eof && !core_rst) |=> logic_en);

    p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stby_s) |=> logic_en);

    p_abort_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PW_DRAIN && core_rst) |=> !logic_en);

    p_reset_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> !frame_open);

endmodule

bind snsr_pwr_ctrl snsr_pwr_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RST_ADDR (RST_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .rd_en      (reg_rd_en),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .core_rst   (core_soft_rst),
    .gexp_rst   (gain_exp_rst),
    .stby_s     (stby_sync),
    .sof        (sof),
    .eof        (eof),
    .state      (pw_state),
    .frame_open (frame_open),
    .logic_en   (logic_en)
);

// File: tb/sim_snsr_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_snsr_pwr_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata;
    logic        sof = 1'b0;
    logic        eof = 1'b0;
    logic        standby_req = 1'b0;
    logic        core_soft_rst;
    logic        gain_exp_rst;
    logic        clk_gate_en;
    logic        logic_en;
    logic        analog_pwr_en;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    snsr_pwr_ctrl u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_rd_en     (reg_rd_en),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .sof           (sof),
        .eof           (eof),
        .standby_req   (standby_req),
        .core_soft_rst (core_soft_rst),
        .gain_exp_rst  (gain_exp_rst),
        .clk_gate_en   (clk_gate_en),
        .logic_en      (logic_en),
        .analog_pwr_en (analog_pwr_en)
    );

    // Behavioural reference: 0 running, 1 waiting for frame end, 2 asleep
    int   m_mode;
    bit   m_frame, m_core, m_gexp, m_on;
    bit   m_req_seen [$];
    int   m_rdata;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_frame = 0; m_core = 0; m_gexp = 0; m_on = 1; m_rdata = 0;
            m_req_seen.delete();
            m_req_seen.push_back(1'b0);
            m_req_seen.push_back(1'b0);
        end else begin
            bit req;
            bit busy;
            req = m_req_seen[0];
            busy = !m_core && ((m_frame && !eof) || sof);
            if (m_mode == 0 && req) m_mode = busy ? 1 : 2;
            else if (m_mode == 1) begin
                if (m_core) m_mode = 2;
                else if (!req) m_mode = 0;
                else if (eof) m_mode = 2;
            end else if (m_mode == 2 && !req) m_mode = 0;
            if (m_core || m_mode == 2) m_frame = 0;
            else if (sof) m_frame = 1;
            else if (eof) m_frame = 0;
            m_on = (m_mode != 2);
            m_core = reg_wr_en && reg_addr == 8'h0C && reg_wdata[0];
            m_gexp = reg_wr_en && reg_addr == 8'h0C && reg_wdata[1];
            m_rdata = 0;
            void'(m_req_seen.pop_front());
            m_req_seen.push_back(standby_req);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(core_soft_rst == m_core, "R1", "model core_soft_rst", core_soft_rst, m_core);
            check(gain_exp_rst == m_gexp, "R2", "model gain_exp_rst", gain_exp_rst, m_gexp);
            check(reg_rdata == 16'(m_rdata), "R4", "model reg_rdata", reg_rdata, m_rdata);
            check(logic_en == m_on && clk_gate_en == m_on && analog_pwr_en == m_on,
                  "R7", "model enables", {clk_gate_en, logic_en, analog_pwr_en}, m_on ? 7 : 0);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        cyc(1);
        reg_wr_en = 1'b0; reg_wdata = 16'h0;
    endtask

    task automatic strobe(input bit s, input bit e);
        sof = s; eof = e;
        cyc(1);
        sof = 1'b0; eof = 1'b0;
    endtask

    function automatic int en3();
        return {clk_gate_en, logic_en, analog_pwr_en};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL all watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R11 reset state
        check(en3() == 7, "R11", "enables after reset", en3(), 7);
        check(!core_soft_rst && !gain_exp_rst, "R11", "pulses after reset",
              {core_soft_rst, gain_exp_rst}, 0);
        check(reg_rdata == 0, "R11", "rdata after reset", reg_rdata, 0);

        // R1 core reset pulse
        wr(8'h0C, 16'h0001);
        check(core_soft_rst == 1, "R1", "core pulse cycle", core_soft_rst, 1);
        check(gain_exp_rst == 0, "R2", "no gexp from bit0", gain_exp_rst, 0);
        cyc(1);
        check(core_soft_rst == 0, "R1", "core pulse width", core_soft_rst, 0);

        // R2 gain/exposure only
        wr(8'h0C, 16'h0002);
        check(gain_exp_rst == 1 && core_soft_rst == 0, "R2", "gexp only",
              {core_soft_rst, gain_exp_rst}, 1);
        cyc(1);
        check(gain_exp_rst == 0, "R2", "gexp pulse width", gain_exp_rst, 0);

        // R3 other address
        wr(8'h0D, 16'h0003);
        check(!core_soft_rst && !gain_exp_rst, "R3", "no pulse off-address",
              {core_soft_rst, gain_exp_rst}, 0);

        // R4 read while pulse active
        wr(8'h0C, 16'h0003);
        reg_rd_en = 1'b1; reg_addr = 8'h0C;
        cyc(1);
        reg_rd_en = 1'b0;
        check(reg_rdata == 0, "R4", "read during pulse", reg_rdata, 0);
        cyc(2);

        // R6 idle shutdown latency
        standby_req = 1'b1;
        cyc(2);
        check(en3() == 7, "R6", "enabled before sync", en3(), 7);
        cyc(1);
        check(en3() == 0, "R6", "idle shutdown", en3(), 0);
        // R8 release latency
        standby_req = 1'b0;
        cyc(2);
        check(en3() == 0, "R8", "asleep before sync", en3(), 0);
        cyc(1);
        check(en3() == 7, "R8", "wake", en3(), 7);

        // R7 wait for end of frame
        strobe(1, 0);
        cyc(2);
        standby_req = 1'b1;
        cyc(6);
        check(en3() == 7, "R7", "held during frame", en3(), 7);
        eof = 1'b1;
        cyc(1);
        eof = 1'b0;
        check(en3() == 0, "R7", "shutdown after eof", en3(), 0);
        standby_req = 1'b0;
        cyc(4);

        // R9 soft reset cancels the wait
        strobe(1, 0);
        standby_req = 1'b1;
        cyc(5);
        wr(8'h0C, 16'h0001);
        check(en3() == 7, "R9", "enabled on pulse cycle", en3(), 7);
        cyc(1);
        check(en3() == 0, "R9", "shutdown after abort", en3(), 0);
        standby_req = 1'b0;
        cyc(4);

        // R5 soft reset closes the frame
        strobe(1, 0);
        cyc(2);
        wr(8'h0C, 16'h0001);
        cyc(2);
        standby_req = 1'b1;
        cyc(3);
        check(en3() == 0, "R5", "no wait after reset", en3(), 0);
        standby_req = 1'b0;
        cyc(4);

        // R10 withdraw during wait
        strobe(1, 0);
        standby_req = 1'b1;
        cyc(5);
        standby_req = 1'b0;
        cyc(5);
        check(en3() == 7, "R10", "withdrawn wait", en3(), 7);
        strobe(0, 1);
        cyc(2);
        check(en3() == 7, "R10", "eof after withdraw", en3(), 7);

        // R12 coincident start and end
        strobe(1, 0);
        cyc(2);
        strobe(1, 1);
        standby_req = 1'b1;
        cyc(6);
        check(en3() == 7, "R12", "new frame waits", en3(), 7);
        eof = 1'b1;
        cyc(1);
        eof = 1'b0;
        check(en3() == 0, "R12", "shutdown after eof", en3(), 0);
        standby_req = 1'b0;
        cyc(4);
        check(en3() == 7, "R8", "final wake", en3(), 7);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule